// File: doc/BRIEF.md
# Segmented Packet Stream Protocol Checker

This block watches a wide packet stream that is cut into a fixed number of segments per clock cycle. Each segment carries its own enable, start and end markers, error bit, empty-byte count and channel number. The checker walks the enabled segments of a cycle from the lowest index to the highest and carries the open-packet state and the current channel from one cycle to the next. It flags four kinds of protocol breach:

- a packet body that arrives without a start marker;
- a second start marker before the end of the open packet;
- a channel change inside a packet while packet mode is selected;
- a nonzero empty count on a segment that is not a packet end.

Each kind has its own sticky flag, and a single pulse marks any cycle that held a breach. A mode input selects packet mode, where the channel must not change within a packet, or burst-interleaved mode, where it may change at any burst. Alongside the checks, the block gives a normalised empty count for every segment. On an errored packet end, the low bits of that count are forced to zero. The checker is a passive monitor and does not alter, hold or reorder traffic.

Top module: `seg_pkt_checker`

## Requirements
- R1: An enabled segment without a start marker, arriving while no packet is open, sets flag bit 0 (missing start). The packet stays closed.
- R2: An enabled segment with a start marker, arriving while a packet is already open, sets flag bit 1 (missing end). The new start then opens a fresh packet on its own channel.
- R3: A segment that carries both start and end markers is a legal single-segment packet. It leaves no packet open and raises no flag.
- R4: In packet mode (`burst_mode`=0), an enabled non-start segment of an open packet whose channel differs from the packet's channel sets flag bit 2.
- R5: In burst-interleaved mode (`burst_mode`=1), channel changes never set flag bit 2.
- R6: `norm_mty` for segment i is 0 unless that segment is enabled and carries an end marker. With an end marker it equals the segment's empty count. When the error bit is also set, the low MTYW-1 bits are forced to 0 and the top bit is kept.
- R7: An enabled segment with a nonzero empty count and no end marker sets flag bit 3.
- R8: Segments whose enable is 0 have no effect on flags, packet state or `norm_mty`, whatever their other fields hold.
- R9: Segments are evaluated in index order within a cycle, so segment i sees the packet state left by segments 0..i-1. That state is carried into the next cycle.
- R10: The flags update one clock after the cycle that holds the breach. They stay set until `clr` is high at a clock edge. A breach in the same cycle as `clr` leaves its flag set.
- R11: `viol_pulse` is high for exactly the one cycle after each cycle that holds any breach, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 0 = packet mode, 1 = burst-interleaved mode |
| clr | input | 1 | Clears sticky flags at the clock edge |
| seg_ena | input | NSEG | Per-segment enable |
| seg_sop | input | NSEG | Per-segment start marker |
| seg_eop | input | NSEG | Per-segment end marker |
| seg_err | input | NSEG | Per-segment error bit (meaningful with end marker) |
| seg_mty | input | NSEG*MTYW | Per-segment empty-byte count, segment i at bits i*MTYW |
| seg_chan | input | NSEG*CHW | Per-segment channel, segment i at bits i*CHW |
| norm_mty | output | NSEG*MTYW | Normalised empty count per segment (combinational) |
| viol_flags | output | 4 | Sticky flags: [0] missing start, [1] missing end, [2] channel change, [3] bad empty count |
| viol_pulse | output | 1 | One-cycle pulse after a cycle holding any breach |

## Verification
Two things can meet in one cycle. The flag clear can coincide with a fresh breach, and two segments of the same cycle can each raise a different breach, one depending on the state the other left behind. The bench provokes the first by driving `clr` together with a start-less segment; the flag must survive while the other flags empty. It provokes the second by opening a packet in segment 0 and changing channel in segment 1, and by closing in one segment and continuing in the next. It judges every cycle against a bench model that walks segments in order and applies the clear-then-set rule.

// File: rtl/seg_pkt_checker.sv
module seg_pkt_checker #(
  parameter int NSEG = 4,
  parameter int CHW  = 11,
  parameter int MTYW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 burst_mode,
  input  logic                 clr,
  input  logic [NSEG-1:0]      seg_ena,
  input  logic [NSEG-1:0]      seg_sop,
  input  logic [NSEG-1:0]      seg_eop,
  input  logic [NSEG-1:0]      seg_err,
  input  logic [NSEG*MTYW-1:0] seg_mty,
  input  logic [NSEG*CHW-1:0]  seg_chan,
  output logic [NSEG*MTYW-1:0] norm_mty,
  output logic [3:0]           viol_flags,
  output logic                 viol_pulse
);

  logic           open_q, open_c;
  logic [CHW-1:0] chan_q, chan_c;
  logic [3:0]     hit;

  always_comb begin
    open_c = open_q;
    chan_c = chan_q;
    hit    = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (seg_ena[i]) begin
        if (seg_sop[i]) begin
          if (open_c) hit[1] = 1'b1;
          open_c = 1'b1;
          chan_c = seg_chan[i*CHW +: CHW];
        end else if (!open_c) begin
          hit[0] = 1'b1;
        end else if (burst_mode) begin
          chan_c = seg_chan[i*CHW +: CHW];
        end else if (seg_chan[i*CHW +: CHW] != chan_c) begin
          hit[2] = 1'b1;
        end
        if (!seg_eop[i] && seg_mty[i*MTYW +: MTYW] != '0) hit[3] = 1'b1;
        if (seg_eop[i]) open_c = 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_norm
    wire [MTYW-1:0] m   = seg_mty[g*MTYW +: MTYW];
    wire            end_ok = seg_ena[g] & seg_eop[g];
    assign norm_mty[g*MTYW +: MTYW] =
      !end_ok    ? '0 :
      seg_err[g] ? {m[MTYW-1], {(MTYW-1){1'b0}}} : m;

    always_comb
      if (rst_n && end_ok && seg_err[g])
        a_r6_err_low_zero: assert (norm_mty[g*MTYW +: MTYW-1] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      chan_q     <= '0;
      viol_flags <= '0;
      viol_pulse <= 1'b0;
    end else begin
      open_q     <= open_c;
      chan_q     <= chan_c;
      viol_flags <= (clr ? 4'b0 : viol_flags) | hit;
      viol_pulse <= |hit;
    end
  end

  a_r10_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

  a_r11_new_flag_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (|(viol_flags & ~$past(viol_flags))) |-> viol_pulse);

  a_r5_burst_no_chan_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flags[2]) |-> !$past(burst_mode));

  a_r11_flag_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_pulse |-> ((viol_flags & ~$past(viol_flags)) == 4'b0));

endmodule

// File: tb/seg_pkt_checker_tb_top.sv
module seg_pkt_checker_tb_top;
  localparam int NSEG = 4, CHW = 11, MTYW = 4;

  logic clk = 0, rst_n = 0, burst_mode = 0, clr = 0;
  logic [NSEG-1:0] seg_ena = 0, seg_sop = 0, seg_eop = 0, seg_err = 0;
  logic [NSEG*MTYW-1:0] seg_mty = 0;
  logic [NSEG*CHW-1:0]  seg_chan = 0;
  logic [NSEG*MTYW-1:0] norm_mty;
  logic [3:0] viol_flags;
  logic viol_pulse;

  int checks = 0, fails = 0;
  bit m_open = 0;
  logic [CHW-1:0] m_chan = 0;
  logic [3:0] m_flags = 0;

  always #2 clk = ~clk;

  seg_pkt_checker #(.NSEG(NSEG), .CHW(CHW), .MTYW(MTYW)) dut_i (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .clr(clr),
    .seg_ena(seg_ena), .seg_sop(seg_sop), .seg_eop(seg_eop), .seg_err(seg_err),
    .seg_mty(seg_mty), .seg_chan(seg_chan), .norm_mty(norm_mty),
    .viol_flags(viol_flags), .viol_pulse(viol_pulse));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    seg_ena = 0; seg_sop = 0; seg_eop = 0; seg_err = 0; seg_mty = 0; seg_chan = 0; clr = 0;
  endtask

  task automatic put(int i, bit e, bit s, bit d, bit r, logic [MTYW-1:0] m, logic [CHW-1:0] c);
    seg_ena[i] = e; seg_sop[i] = s; seg_eop[i] = d; seg_err[i] = r;
    seg_mty[i*MTYW +: MTYW] = m; seg_chan[i*CHW +: CHW] = c;
  endtask

  // R6/R8: expected normalised empty count
  function automatic logic [MTYW-1:0] exp_norm(int i);
    logic [MTYW-1:0] m = seg_mty[i*MTYW +: MTYW];
    if (!(seg_ena[i] && seg_eop[i])) return 0;
    if (seg_err[i]) return {m[MTYW-1], {(MTYW-1){1'b0}}};
    return m;
  endfunction

  // R1 R2 R4 R5 R7 R9: in-order walk over the segments of a cycle
  function automatic logic [3:0] model_cycle();
    logic [3:0] v = 0;
    for (int i = 0; i < NSEG; i++) begin
      logic [CHW-1:0] c = seg_chan[i*CHW +: CHW];
      if (!seg_ena[i]) continue;
      if (seg_sop[i]) begin
        if (m_open) v[1] = 1;
        m_open = 1; m_chan = c;
      end else if (!m_open) v[0] = 1;
      else if (burst_mode) m_chan = c;
      else if (c != m_chan) v[2] = 1;
      if (!seg_eop[i] && seg_mty[i*MTYW +: MTYW] != 0) v[3] = 1;
      if (seg_eop[i]) m_open = 0;
    end
    return v;
  endfunction

  task automatic step();
    logic [3:0] v;
    #1;
    for (int i = 0; i < NSEG; i++) chk("R6 norm_mty", norm_mty[i*MTYW +: MTYW], exp_norm(i));
    v = model_cycle();
    m_flags = (clr ? 4'b0 : m_flags) | v; // R10
    @(posedge clk); #1;
    chk("R1 flag0", viol_flags[0], m_flags[0]);
    chk("R2 flag1", viol_flags[1], m_flags[1]);
    chk("R4 flag2", viol_flags[2], m_flags[2]);
    chk("R7 flag3", viol_flags[3], m_flags[3]);
    chk("R11 pulse", viol_pulse, |v);
    @(negedge clk);
    idle();
  endtask

  task automatic do_clear();
    clr = 1; step();
  endtask

  bit gen_open = 0;
  logic [CHW-1:0] gen_chan = 0;

  task automatic rand_cycle();
    for (int i = 0; i < NSEG; i++) begin
      bit e = ($urandom % 4) != 0;
      bit s = gen_open ? (($urandom % 16) == 0) : (($urandom % 16) != 0);
      bit d = ($urandom % 3) == 0;
      bit r = ($urandom % 4) == 0;
      logic [MTYW-1:0] m = d ? MTYW'($urandom) : ((($urandom % 16) == 0) ? MTYW'($urandom) : '0);
      logic [CHW-1:0] c;
      if (s) gen_chan = CHW'($urandom % 8);
      c = (($urandom % 12) == 0) ? CHW'($urandom % 8) : gen_chan;
      put(i, e, s, d, r, m, c);
      if (e && s) gen_open = 1;
      if (e && d) gen_open = 0;
    end
    clr = ($urandom % 20) == 0;
    step();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R10 reset flags", viol_flags, 0);
    chk("R11 reset pulse", viol_pulse, 0);

    // R3: single-segment packets in every slot
    for (int i = 0; i < NSEG; i++) put(i, 1, 1, 1, 0, MTYW'(i), CHW'(i));
    step();
    chk("R3 no flag after single-seg", viol_flags, 0);

    // R1: body without start
    put(0, 1, 0, 0, 0, 0, 5); step();
    chk("R1 missing start", viol_flags[0], 1);
    do_clear();
    chk("R10 cleared", viol_flags, 0);

    // R2: second start while open
    put(0, 1, 1, 0, 0, 0, 3); put(2, 1, 1, 1, 0, 0, 4); step();
    chk("R2 missing end", viol_flags[1], 1);
    do_clear();

    // R4 + R9: open in seg0, wrong channel in seg1 of the same cycle
    put(0, 1, 1, 0, 0, 0, 7); put(1, 1, 0, 1, 0, 0, 8); step();
    chk("R4 channel change", viol_flags[2], 1);
    do_clear();

    // R5: burst mode, channel changes across cycles
    burst_mode = 1;
    put(3, 1, 1, 0, 0, 0, 1); step();
    put(0, 1, 0, 0, 0, 0, 2); put(1, 1, 0, 1, 0, 0, 9); step();
    chk("R5 burst no flag", viol_flags, 0);
    burst_mode = 0;

    // R7: empty count on non-end segment
    put(0, 1, 1, 0, 0, 4'h3, 1); step();
    chk("R7 bad empty", viol_flags[3], 1);
    put(0, 1, 0, 1, 0, 0, 1); step();
    do_clear();

    // R8: disabled garbage segments change nothing
    for (int i = 0; i < NSEG; i++) put(i, 0, 1, 0, 1, 4'hF, CHW'(i + 20));
    step();
    chk("R8 disabled ignored", viol_flags, 0);
    chk("R8 norm zero", norm_mty, 0);

    // R9: open in seg3, continue next cycle seg0, end seg1; then close/body in same cycle
    put(3, 1, 1, 0, 0, 0, 6); step();
    put(0, 1, 0, 0, 0, 0, 6); put(1, 1, 0, 1, 0, 0, 6); put(2, 1, 0, 1, 0, 0, 6); step();
    chk("R9 order: seg2 body after close", viol_flags, 4'b0001);

    // R10: clear and a new breach in the same cycle
    clr = 1; put(0, 1, 0, 1, 0, 0, 1); step();
    chk("R10 clear loses to breach", viol_flags, 4'b0001);
    do_clear();

    // R6: errored end, top bit kept
    put(0, 1, 1, 1, 1, 4'hF, 2); put(1, 1, 1, 1, 1, 4'h7, 2);
    #1;
    chk("R6 err top kept", norm_mty[3:0], 4'h8);
    chk("R6 err low zero", norm_mty[7:4], 4'h0);
    step();

    for (int k = 0; k < 3000; k++) begin
      if (k % 500 == 0) burst_mode = $urandom % 2;
      rand_cycle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule